// File: doc/BRIEF.md
# Translation Invalidation Shootdown Controller

This block runs the hardware side of a cross-core translation invalidation. There is one instance per core. When the local core asks for a shootdown of one translation entry, the initiator side first locks that entry. It then derives a conservative set of target cores and fans out an inter-core invalidate request to all of them in one cycle. In that same cycle it pulses the invalidate for its own copy of the entry. After that it waits for every target to answer. The lock drops only when all targeted cores have acknowledged, and a one-cycle done pulse marks that point.

The responder side of the same instance serves requests that other cores' initiators send here. Each incoming request produces a local invalidate pulse for the named entry one cycle later. A one-hot acknowledgement addressed to the requesting core follows one cycle after that. The page-table walker, the translation arrays and any software handlers sit outside the block and are reached only through these pulse-style handshakes.

The parameter `TARGET_MODE` selects how targets are chosen. Mode 0 (the default) always targets every core except the local one. Mode 1 targets the sharers named by a holder hint, again with the local core removed.

Top module: `tlb_shootdown_ctrl`

## Requirements
- R1: After reset the entry lock, busy, done, fan-out request, local invalidate, responder invalidate and acknowledgement outputs are all low, and the fan-out mask is zero.
- R2: A shootdown request seen while the controller is idle is taken at that clock edge. From the next cycle the lock output is high, busy is high, and the lock entry output shows the requested entry.
- R3: The fan-out request is never raised in the first locked cycle. It is raised for exactly one cycle, in the second locked cycle.
- R4: In the default mode the fan-out mask has a 1 for every core other than the local one (bit i is core i; with four cores and local core 0 it is 4'b1110), whatever the holder hint says. The local core's bit is never set.
- R5: The local invalidate pulses for exactly one cycle, in the same cycle as the fan-out request, and carries the locked entry.
- R6: The lock stays high until acknowledgements from all targeted cores have arrived. If the last of them is presented in cycle k, done is high in cycle k+1 and the lock is low from cycle k+2.
- R7: An acknowledgement on the local core's bit, or a second acknowledgement from a core that has already answered, does not change when done is raised or when the lock is released.
- R8: A new shootdown request made while the lock is held is not taken and does not alter the lock entry. If it is held, it is taken at the second clock edge after the done cycle.
- R9: Done is high for exactly one cycle per shootdown, in the last cycle of the lock.
- R10: An incoming invalidate request seen in cycle k gives a responder invalidate pulse carrying the same entry in cycle k+1. In cycle k+2 it gives an acknowledgement whose one-hot destination has bit s set for source core s. Requests on consecutive cycles are each served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_req_i | input | 1 | Local core asks for a shootdown |
| sd_entry_i | input | ENTRY_W | Entry to invalidate |
| sd_holders_i | input | NCORES | Sharer hint, used in mode 1 only |
| sd_busy_o | output | 1 | High while a shootdown owns the lock |
| sd_done_o | output | 1 | One-cycle completion pulse |
| pte_lock_o | output | 1 | Entry lock held |
| pte_lock_entry_o | output | ENTRY_W | Entry under lock |
| ipi_valid_o | output | 1 | Fan-out invalidate request |
| ipi_mask_o | output | NCORES | Cores targeted by the fan-out |
| ipi_entry_o | output | ENTRY_W | Entry carried by the fan-out |
| local_inv_o | output | 1 | Invalidate pulse for the own translation |
| local_inv_entry_o | output | ENTRY_W | Entry of the own invalidate |
| ack_i | input | NCORES | Acknowledgements, one bit per core |
| rx_valid_i | input | 1 | Incoming invalidate request from another core |
| rx_entry_i | input | ENTRY_W | Entry of the incoming request |
| rx_src_i | input | $clog2(NCORES) | Index of the requesting core |
| rx_inv_o | output | 1 | Responder invalidate pulse |
| rx_inv_entry_o | output | ENTRY_W | Entry of the responder invalidate |
| ack_valid_o | output | 1 | Acknowledgement to a requester |
| ack_dst_o | output | NCORES | One-hot destination of the acknowledgement |

## Verification
The bound checker watches, on every cycle, the ordering of lock, fan-out and local invalidate, and that the local core never appears in the fan-out. It also checks that done lasts one cycle and is followed by the release. It keeps its own copy of the outstanding acknowledgements and checks that the lock never falls while that copy is non-zero. It checks that the responder pipeline answers each request with one invalidate and one one-hot acknowledgement. Only the bench scenarios can show the exact completion cycle under mixed acknowledgement delays, the unchanged timing when stray and repeated acknowledgements arrive, and the hand-over to a request that was stalled. The exact mask value against an arbitrary holder hint is also shown only by the bench.

// File: rtl/tlbsd_pkg.sv
`timescale 1ns/1ps
package tlbsd_pkg;

   typedef enum logic [1:0] {
      SD_IDLE = 2'd0,
      SD_LOCK = 2'd1,
      SD_SEND = 2'd2,
      SD_WAIT = 2'd3
   } sd_state_e;

endpackage

// File: rtl/tlbsd_target.sv
`timescale 1ns/1ps
// Target selection: always excludes the local core.
module tlbsd_target #(
   parameter int NCORES      = 4,
   parameter int SELF_ID     = 0,
   parameter int TARGET_MODE = 0
) (
   input  logic [NCORES-1:0] holders_i,
   output logic [NCORES-1:0] mask_o
);
   localparam logic [NCORES-1:0] SELF_BIT = NCORES'(1) << SELF_ID;

   generate
      if (TARGET_MODE == 0) begin : g_bcast
         logic unused_hint;
         assign unused_hint = ^holders_i;
         assign mask_o      = ~SELF_BIT;
      end else begin : g_hint
         assign mask_o = holders_i & ~SELF_BIT;
      end
   endgenerate
endmodule

// File: rtl/tlbsd_initiator.sv
`timescale 1ns/1ps
module tlbsd_initiator
   import tlbsd_pkg::*;
#(
   parameter int NCORES  = 4,
   parameter int ENTRY_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [ENTRY_W-1:0] entry_i,
   input  logic [NCORES-1:0]  tgt_i,
   input  logic [NCORES-1:0]  ack_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               lock_o,
   output logic [ENTRY_W-1:0] lock_entry_o,
   output logic               ipi_valid_o,
   output logic [NCORES-1:0]  ipi_mask_o,
   output logic [ENTRY_W-1:0] ipi_entry_o,
   output logic               local_inv_o,
   output logic [ENTRY_W-1:0] local_inv_entry_o
);
   sd_state_e          state_q;
   logic [ENTRY_W-1:0] ent_q;
   logic [NCORES-1:0]  tgt_q;
   logic [NCORES-1:0]  pend_q;
   logic               pend_clear;

   assign pend_clear = (pend_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SD_IDLE;
         ent_q   <= '0;
         tgt_q   <= '0;
         pend_q  <= '0;
      end else begin
         case (state_q)
            SD_IDLE: begin
               if (req_i) begin
                  state_q <= SD_LOCK;
                  ent_q   <= entry_i;
                  tgt_q   <= tgt_i;
               end
            end
            SD_LOCK: state_q <= SD_SEND;
            SD_SEND: begin
               // outstanding set loaded from the targets; stray bits masked off
               pend_q  <= tgt_q & ~ack_i;
               state_q <= SD_WAIT;
            end
            SD_WAIT: begin
               pend_q <= pend_q & ~ack_i;
               if (pend_clear) state_q <= SD_IDLE;
            end
            default: state_q <= SD_IDLE;
         endcase
      end
   end

   always_comb begin
      lock_o            = (state_q != SD_IDLE);
      busy_o            = lock_o;
      lock_entry_o      = ent_q;
      ipi_valid_o       = (state_q == SD_SEND);
      ipi_mask_o        = ipi_valid_o ? tgt_q : '0;
      ipi_entry_o       = ent_q;
      local_inv_o       = ipi_valid_o;
      local_inv_entry_o = ent_q;
      done_o            = (state_q == SD_WAIT) && pend_clear;
   end
endmodule

// File: rtl/tlbsd_responder.sv
`timescale 1ns/1ps
module tlbsd_responder #(
   parameter int NCORES  = 4,
   parameter int ENTRY_W = 8,
   parameter int IDW     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid_i,
   input  logic [ENTRY_W-1:0] rx_entry_i,
   input  logic [IDW-1:0]     rx_src_i,
   output logic               inv_o,
   output logic [ENTRY_W-1:0] inv_entry_o,
   output logic               ack_valid_o,
   output logic [NCORES-1:0]  ack_dst_o
);
   logic               s1_v, s2_v;
   logic [ENTRY_W-1:0] s1_entry;
   logic [IDW-1:0]     s1_src, s2_src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v     <= 1'b0;
         s2_v     <= 1'b0;
         s1_entry <= '0;
         s1_src   <= '0;
         s2_src   <= '0;
      end else begin
         s1_v     <= rx_valid_i;
         s1_entry <= rx_entry_i;
         s1_src   <= rx_src_i;
         s2_v     <= s1_v;
         s2_src   <= s1_src;
      end
   end

   assign inv_o       = s1_v;
   assign inv_entry_o = s1_entry;
   assign ack_valid_o = s2_v;

   generate
      for (genvar c = 0; c < NCORES; c++) begin : g_dst
         assign ack_dst_o[c] = s2_v && (s2_src == IDW'(c));
      end
   endgenerate
endmodule

// File: rtl/tlb_shootdown_ctrl.sv
`timescale 1ns/1ps
module tlb_shootdown_ctrl #(
   parameter int NCORES      = 4,
   parameter int ENTRY_W     = 8,
   parameter int SELF_ID     = 0,
   parameter int TARGET_MODE = 0,
   localparam int IDW        = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sd_req_i,
   input  logic [ENTRY_W-1:0] sd_entry_i,
   input  logic [NCORES-1:0]  sd_holders_i,
   output logic               sd_busy_o,
   output logic               sd_done_o,
   output logic               pte_lock_o,
   output logic [ENTRY_W-1:0] pte_lock_entry_o,
   output logic               ipi_valid_o,
   output logic [NCORES-1:0]  ipi_mask_o,
   output logic [ENTRY_W-1:0] ipi_entry_o,
   output logic               local_inv_o,
   output logic [ENTRY_W-1:0] local_inv_entry_o,
   input  logic [NCORES-1:0]  ack_i,
   input  logic               rx_valid_i,
   input  logic [ENTRY_W-1:0] rx_entry_i,
   input  logic [IDW-1:0]     rx_src_i,
   output logic               rx_inv_o,
   output logic [ENTRY_W-1:0] rx_inv_entry_o,
   output logic               ack_valid_o,
   output logic [NCORES-1:0]  ack_dst_o
);
   generate
      if (NCORES < 2) begin : g_bad_ncores
         $error("tlb_shootdown_ctrl: NCORES must be at least 2");
      end
      if (SELF_ID < 0 || SELF_ID >= NCORES) begin : g_bad_self
         $error("tlb_shootdown_ctrl: SELF_ID out of range");
      end
      if (ENTRY_W < 1) begin : g_bad_entry
         $error("tlb_shootdown_ctrl: ENTRY_W must be positive");
      end
      if (TARGET_MODE != 0 && TARGET_MODE != 1) begin : g_bad_mode
         $error("tlb_shootdown_ctrl: TARGET_MODE must be 0 or 1");
      end
   endgenerate

   logic [NCORES-1:0] tgt_mask;

   tlbsd_target #(
      .NCORES(NCORES), .SELF_ID(SELF_ID), .TARGET_MODE(TARGET_MODE)
   ) i_target (
      .holders_i(sd_holders_i),
      .mask_o   (tgt_mask)
   );

   tlbsd_initiator #(
      .NCORES(NCORES), .ENTRY_W(ENTRY_W)
   ) i_init (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_i            (sd_req_i),
      .entry_i          (sd_entry_i),
      .tgt_i            (tgt_mask),
      .ack_i            (ack_i),
      .busy_o           (sd_busy_o),
      .done_o           (sd_done_o),
      .lock_o           (pte_lock_o),
      .lock_entry_o     (pte_lock_entry_o),
      .ipi_valid_o      (ipi_valid_o),
      .ipi_mask_o       (ipi_mask_o),
      .ipi_entry_o      (ipi_entry_o),
      .local_inv_o      (local_inv_o),
      .local_inv_entry_o(local_inv_entry_o)
   );

   tlbsd_responder #(
      .NCORES(NCORES), .ENTRY_W(ENTRY_W), .IDW(IDW)
   ) i_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid_i (rx_valid_i),
      .rx_entry_i (rx_entry_i),
      .rx_src_i   (rx_src_i),
      .inv_o      (rx_inv_o),
      .inv_entry_o(rx_inv_entry_o),
      .ack_valid_o(ack_valid_o),
      .ack_dst_o  (ack_dst_o)
   );
endmodule

// File: rtl/tlbsd_chk.sv
`timescale 1ns/1ps
module tlbsd_chk #(
   parameter int NCORES  = 4,
   parameter int ENTRY_W = 8,
   parameter int SELF_ID = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sd_busy_o,
   input logic               sd_done_o,
   input logic               pte_lock_o,
   input logic [ENTRY_W-1:0] pte_lock_entry_o,
   input logic               ipi_valid_o,
   input logic [NCORES-1:0]  ipi_mask_o,
   input logic [ENTRY_W-1:0] ipi_entry_o,
   input logic               local_inv_o,
   input logic [ENTRY_W-1:0] local_inv_entry_o,
   input logic [NCORES-1:0]  ack_i,
   input logic               rx_valid_i,
   input logic               rx_inv_o,
   input logic               ack_valid_o,
   input logic [NCORES-1:0]  ack_dst_o
);
   // independent record of outstanding acknowledgements
   logic [NCORES-1:0] chk_pend;
   always_ff @(posedge clk) begin
      if (!rst_n)           chk_pend <= '0;
      else if (ipi_valid_o) chk_pend <= ipi_mask_o & ~ack_i;
      else                  chk_pend <= chk_pend & ~ack_i;
   end

   // R3
   ipi_under_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_valid_o |-> pte_lock_o);
   // R3
   ipi_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pte_lock_o) |=> ipi_valid_o);
   // R4
   no_self_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_valid_o |-> !ipi_mask_o[SELF_ID]);
   // R5
   local_with_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_valid_o |-> (local_inv_o && local_inv_entry_o == ipi_entry_o
                       && ipi_entry_o == pte_lock_entry_o));
   // R5
   local_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      local_inv_o |=> !local_inv_o);
   // R6
   release_all_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pte_lock_o) |-> (chk_pend == '0));
   // R7
   no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pte_lock_o && !ipi_valid_o && chk_pend != '0) |-> !sd_done_o);
   // R8
   entry_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pte_lock_o && $past(pte_lock_o)) |-> $stable(pte_lock_entry_o));
   // R9
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sd_done_o |-> sd_busy_o ##1 (!pte_lock_o && !sd_done_o));
   // R10
   rx_inv_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i |=> rx_inv_o);
   // R10
   rx_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_inv_o |=> (ack_valid_o && $countones(ack_dst_o) == 1));
   // R10
   ack_dst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_valid_o |-> (ack_dst_o == '0));
endmodule

bind tlb_shootdown_ctrl tlbsd_chk #(
   .NCORES(NCORES), .ENTRY_W(ENTRY_W), .SELF_ID(SELF_ID)
) i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .sd_busy_o        (sd_busy_o),
   .sd_done_o        (sd_done_o),
   .pte_lock_o       (pte_lock_o),
   .pte_lock_entry_o (pte_lock_entry_o),
   .ipi_valid_o      (ipi_valid_o),
   .ipi_mask_o       (ipi_mask_o),
   .ipi_entry_o      (ipi_entry_o),
   .local_inv_o      (local_inv_o),
   .local_inv_entry_o(local_inv_entry_o),
   .ack_i            (ack_i),
   .rx_valid_i       (rx_valid_i),
   .rx_inv_o         (rx_inv_o),
   .ack_valid_o      (ack_valid_o),
   .ack_dst_o        (ack_dst_o)
);

// File: tb/test_tlb_shootdown_ctrl.sv
`timescale 1ns/1ps
module test_tlb_shootdown_ctrl;
   localparam int NC  = 4;
   localparam int EW  = 8;
   localparam int IDW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          sd_req_i = 1'b0;
   logic [EW-1:0] sd_entry_i = '0;
   logic [NC-1:0] sd_holders_i = 4'b0010;
   logic          sd_busy_o, sd_done_o, pte_lock_o;
   logic [EW-1:0] pte_lock_entry_o, ipi_entry_o, local_inv_entry_o, rx_inv_entry_o;
   logic          ipi_valid_o, local_inv_o, rx_inv_o, ack_valid_o;
   logic [NC-1:0] ipi_mask_o, ack_dst_o;
   logic [NC-1:0] ack_i = '0;
   logic          rx_valid_i = 1'b0;
   logic [EW-1:0] rx_entry_i = '0;
   logic [IDW-1:0] rx_src_i = '0;

   tlb_shootdown_ctrl #(.NCORES(NC), .ENTRY_W(EW), .SELF_ID(0), .TARGET_MODE(0))
   i_tlb_shootdown_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sd_req_i(sd_req_i), .sd_entry_i(sd_entry_i), .sd_holders_i(sd_holders_i),
      .sd_busy_o(sd_busy_o), .sd_done_o(sd_done_o),
      .pte_lock_o(pte_lock_o), .pte_lock_entry_o(pte_lock_entry_o),
      .ipi_valid_o(ipi_valid_o), .ipi_mask_o(ipi_mask_o), .ipi_entry_o(ipi_entry_o),
      .local_inv_o(local_inv_o), .local_inv_entry_o(local_inv_entry_o),
      .ack_i(ack_i),
      .rx_valid_i(rx_valid_i), .rx_entry_i(rx_entry_i), .rx_src_i(rx_src_i),
      .rx_inv_o(rx_inv_o), .rx_inv_entry_o(rx_inv_entry_o),
      .ack_valid_o(ack_valid_o), .ack_dst_o(ack_dst_o)
   );

   typedef struct { logic [EW-1:0] e; logic [NC-1:0] m; } ipi_t;
   typedef struct { logic [EW-1:0] e; int due; } rx_t;
   typedef struct { logic [NC-1:0] d; int due; } ack_t;
   ipi_t exp_ipi[$];
   rx_t  exp_rx[$];
   ack_t exp_ack[$];

   int  cyc = 0;
   int  n_chk = 0, n_fail = 0;
   int  dly[NC] = '{0, 1, 1, 1};
   int  ack_due[NC] = '{-100, -100, -100, -100};
   int  exp_done_cyc = -100;
   bit  stray_en = 1'b0;
   bit  prev_lock = 1'b0, prev_ipi = 1'b0;
   bit  finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk_eq(input string req, input string what,
                         input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // monitor: pops expected items as results appear, then drives the remote-core acks
   always @(negedge clk) begin
      if (rst_n) begin
         if (ipi_valid_o) begin
            int mx;
            if (exp_ipi.size() == 0) chk_eq("R3", "unexpected fan-out", 1, 0);
            else begin
               ipi_t it;
               it = exp_ipi.pop_front();
               chk_eq("R4", "fan-out mask", ipi_mask_o, it.m);
               chk_eq("R5", "fan-out entry", ipi_entry_o, it.e);
               chk_eq("R5", "local invalidate entry", local_inv_entry_o, it.e);
            end
            chk_eq("R5", "local invalidate with fan-out", local_inv_o, 1);
            chk_eq("R3", "lock one cycle before fan-out", {prev_lock, prev_ipi}, 2'b10);
            mx = 0;
            for (int j = 0; j < NC; j++) begin
               if (ipi_mask_o[j]) begin
                  ack_due[j] = cyc + dly[j];
                  if (dly[j] > mx) mx = dly[j];
               end
            end
            exp_done_cyc = cyc + mx + 1;
         end else if (local_inv_o) begin
            chk_eq("R5", "local invalidate without fan-out", 1, 0);
         end
         if (cyc == exp_done_cyc - 1) begin
            chk_eq("R6", "lock before last ack seen", pte_lock_o, 1);
            chk_eq("R6", "done before last ack seen", sd_done_o, 0);
         end
         if (cyc == exp_done_cyc) begin
            chk_eq("R9", "done in last lock cycle", sd_done_o, 1);
            chk_eq("R6", "lock in done cycle", pte_lock_o, 1);
         end
         if (cyc == exp_done_cyc + 1) begin
            chk_eq("R6", "lock after done", pte_lock_o, 0);
            chk_eq("R9", "done width", sd_done_o, 0);
         end
         if (sd_done_o && cyc != exp_done_cyc) chk_eq("R7", "done at wrong cycle", cyc, exp_done_cyc);
         if (rx_inv_o) begin
            if (exp_rx.size() == 0) chk_eq("R10", "unexpected responder invalidate", 1, 0);
            else begin
               rx_t r;
               r = exp_rx.pop_front();
               chk_eq("R10", "responder entry", rx_inv_entry_o, r.e);
               chk_eq("R10", "responder invalidate cycle", cyc, r.due);
            end
         end
         if (ack_valid_o) begin
            if (exp_ack.size() == 0) chk_eq("R10", "unexpected ack out", 1, 0);
            else begin
               ack_t a;
               a = exp_ack.pop_front();
               chk_eq("R10", "ack destination", ack_dst_o, a.d);
               chk_eq("R10", "ack cycle", cyc, a.due);
            end
         end
         prev_lock = pte_lock_o;
         prev_ipi  = ipi_valid_o;
         for (int j = 0; j < NC; j++) ack_i[j] = (cyc == ack_due[j]);
         if (stray_en) begin
            ack_i[0] = 1'b1;                              // own bit: never targeted
            if (cyc == ack_due[1] + 1) ack_i[1] = 1'b1;   // repeated ack
         end
      end else begin
         ack_i = '0;
      end
   end

   task automatic wait_idle();
      int guard;
      guard = 0;
      while (sd_busy_o && guard < 500) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic shoot(input logic [EW-1:0] e, input int d1, input int d2,
                        input int d3, input bit stray);
      wait_idle();
      dly = '{0, d1, d2, d3};
      stray_en = stray;
      chk_eq("R2", "idle before request", sd_busy_o, 0);
      exp_ipi.push_back('{e, 4'b1110});
      sd_req_i = 1'b1;
      sd_entry_i = e;
      @(negedge clk);
      chk_eq("R2", "lock taken", pte_lock_o, 1);
      chk_eq("R2", "busy", sd_busy_o, 1);
      chk_eq("R2", "lock entry", pte_lock_entry_o, e);
      sd_req_i = 1'b0;
      wait_idle();
      @(negedge clk);
      stray_en = 1'b0;
   endtask

   task automatic stall_pair(input logic [EW-1:0] ea, input logic [EW-1:0] eb);
      int guard;
      wait_idle();
      dly = '{0, 4, 2, 4};
      exp_ipi.push_back('{ea, 4'b1110});
      exp_ipi.push_back('{eb, 4'b1110});
      sd_req_i = 1'b1;
      sd_entry_i = ea;
      @(negedge clk);
      chk_eq("R8", "first entry locked", pte_lock_entry_o, ea);
      sd_entry_i = eb;
      guard = 0;
      while (!(pte_lock_o && pte_lock_entry_o == eb) && guard < 200) begin
         @(negedge clk);
         guard++;
         if (pte_lock_o && pte_lock_entry_o != ea && pte_lock_entry_o != eb)
            chk_eq("R8", "lock entry disturbed", pte_lock_entry_o, ea);
      end
      chk_eq("R8", "stalled request taken two edges after done", cyc, exp_done_cyc + 2);
      chk_eq("R8", "one idle cycle before hand-over", prev_lock, 0);
      sd_req_i = 1'b0;
      wait_idle();
      @(negedge clk);
   endtask

   task automatic rx_send(input logic [EW-1:0] e, input logic [IDW-1:0] s);
      rx_valid_i = 1'b1;
      rx_entry_i = e;
      rx_src_i   = s;
      exp_rx.push_back('{e, cyc + 1});
      exp_ack.push_back('{NC'(1) << s, cyc + 2});
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_eq("R1", "lock", pte_lock_o, 0);
      chk_eq("R1", "busy", sd_busy_o, 0);
      chk_eq("R1", "done", sd_done_o, 0);
      chk_eq("R1", "fan-out", {ipi_valid_o, ipi_mask_o}, 0);
      chk_eq("R1", "local invalidate", local_inv_o, 0);
      chk_eq("R1", "responder", {rx_inv_o, ack_valid_o, ack_dst_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      shoot(8'h29, 1, 1, 1, 1'b0);   // R2 R3 R4 R5 R6 R9: equal delays
      shoot(8'h35, 6, 2, 9, 1'b0);   // R6: slowest core decides
      sd_holders_i = 4'b1001;        // R4: hint ignored in default mode
      shoot(8'hA7, 3, 5, 8, 1'b1);   // R7: stray own-bit and repeated acks
      sd_holders_i = 4'b0000;
      stall_pair(8'h11, 8'h22);      // R8: stalled request hand-over

      rx_send(8'h5C, 2'd2);          // R10: back-to-back requests
      rx_send(8'h06, 2'd3);
      rx_send(8'hF0, 2'd1);
      rx_valid_i = 1'b0;
      repeat (4) @(negedge clk);

      chk_eq("R4", "fan-outs left unseen", exp_ipi.size(), 0);
      chk_eq("R10", "responder items left unseen", exp_rx.size() + exp_ack.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all): actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule